// File: doc/BRIEF.md
# Display Bridge Power-Up Sequencer

This block takes a parallel-RGB-to-DSI bridge from a cold state to streaming video. After a start pulse it pulses the bridge reset line and optionally confirms the bridge identity through two register reads. It then programs the panel timing, pixel format, lane count, configuration word, PLL and low-power clock divider. While the link is still in low-power mode it sends two display commands, waiting a programmable number of milliseconds after each. Last, it switches the data lanes to high speed and turns on the video pipeline.

All register traffic leaves through a simple command port. The port carries a valid/ready request with a write flag, an 8-bit register address and 16-bit data, and a separate one-cycle response strobe that returns read data. A serial master outside this block does the framing. Panel timing, colour depth, lane count, the PLL word, the divider field and both delays are static inputs, held steady while a run is in progress. Every wait is counted in clock cycles derived from parameters that give clocks per microsecond and microseconds per millisecond.

Top module: `dsi_bridge_seq`

## Requirements
- R1: After reset, `done`, `error` and `cmd_valid` are low and `bridge_rst_n` is high.
- R2: A start pulse drives `bridge_rst_n` low for exactly RESET_MS milliseconds' worth of cycles, then high for the same number of cycles before the first request appears.
- R3: With `readback_en` high, the block first reads register 0xB0, which must return 0x2828, and then reads 0xB7, which must return 0x0301. Any mismatch raises `error` and no further request is issued. With `readback_en` low, both reads are skipped.
- R4: The first writes, in this order, are: 0xB1 = {vsync width, hsync width}; 0xB2 = {vsync width + vertical back porch, hsync width + horizontal back porch}, each sum kept to 8 bits; 0xB3 = {vertical front porch, horizontal front porch}; 0xB4 = horizontal active pixels; 0xB5 = vertical active lines. In each pair the first item is the high byte.
- R5: 0xB6 is then written with 0x0008 ORed with a format code: 0 for 16 bpp, 1 for packed 18 bpp, 2 for loose 18 bpp and 3 for 24 bpp. For any other depth the block raises `error` without writing 0xB6 or anything after it.
- R6: 0xDE is written with the lane count minus one. 0xB7 is then written with the low-power configuration: 0x0342, or 0x0362 when `tx_clk_khz` is zero.
- R7: 0xBA = PLL word, 0xB8 = 0, 0xBB = divider field and 0xB9 = 1 follow in that order. After 0xB9 is accepted, no request is made for exactly PLL_US microseconds' worth of cycles.
- R8: Each display command is sent as 0xBC = 1 followed by 0xBF = command byte. Exit-sleep (0x11) comes first and display-on (0x29) second. After each 0xBF write the block issues no request for exactly the programmed millisecond delay of that command, in cycles.
- R9: The last write is 0xB7 = low-power configuration | 0x0009, which gives 0x034B or 0x036B. After it is accepted, `done` goes high and stays high.
- R10: A request holds its address, data and write flag until it is accepted with `cmd_ready`. A read waits for `rsp_valid` before the sequence continues.
- R11: `start` is ignored while a run is in progress. In the idle, done or error state it begins a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a power-up run |
| readback_en | input | 1 | Bridge read path is available; do the identity check |
| tx_clk_khz | input | 16 | Transmit reference clock in kHz; zero selects the pixel clock |
| vs_width | input | 8 | Vertical sync width |
| hs_width | input | 8 | Horizontal sync width |
| v_back | input | 8 | Vertical back porch |
| h_back | input | 8 | Horizontal back porch |
| v_front | input | 8 | Vertical front porch |
| h_front | input | 8 | Horizontal front porch |
| h_active | input | 16 | Active pixels per line |
| v_active | input | 16 | Active lines per frame |
| color_bits | input | 5 | Colour depth in bits per pixel |
| loose18 | input | 1 | Loose packing for 18 bpp |
| lane_cnt | input | 3 | Number of data lanes (1 to 4) |
| pll_word | input | 16 | PLL configuration word |
| lp_div | input | 16 | Low-power clock divider field |
| sleep_exit_ms | input | DLY_W | Delay after the exit-sleep command |
| disp_on_ms | input | DLY_W | Delay after the display-on command |
| bridge_rst_n | output | 1 | Bridge reset, active low |
| cmd_valid | output | 1 | Register request valid |
| cmd_ready | input | 1 | Request accepted |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | 8 | Register address |
| cmd_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Read data strobe |
| rsp_data | input | 16 | Read data |
| done | output | 1 | Run finished, video streaming |
| error | output | 1 | Run aborted |

## Verification
Two events can land on the same clock edge: a new start request and the acceptance of the final configuration write. That same edge moves the block into its done state. The bench raises `start` in exactly the cycle in which its responder accepts the last 0xB7 write. It then checks that `done` rises and stays high, and that the bridge reset line is not pulsed again. A second start is also sent in the middle of the reset-high wait; the scoreboard must still see one unbroken, correctly ordered run.

// File: rtl/dsi_bridge_seq.sv
module dsi_bridge_seq #(
  parameter int CLKS_PER_US = 100,
  parameter int US_PER_MS   = 1000,
  parameter int RESET_MS    = 10,
  parameter int PLL_US      = 500,
  parameter int DLY_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             readback_en,
  input  logic [15:0]      tx_clk_khz,
  input  logic [7:0]       vs_width,
  input  logic [7:0]       hs_width,
  input  logic [7:0]       v_back,
  input  logic [7:0]       h_back,
  input  logic [7:0]       v_front,
  input  logic [7:0]       h_front,
  input  logic [15:0]      h_active,
  input  logic [15:0]      v_active,
  input  logic [4:0]       color_bits,
  input  logic             loose18,
  input  logic [2:0]       lane_cnt,
  input  logic [15:0]      pll_word,
  input  logic [15:0]      lp_div,
  input  logic [DLY_W-1:0] sleep_exit_ms,
  input  logic [DLY_W-1:0] disp_on_ms,
  output logic             bridge_rst_n,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic             cmd_write,
  output logic [7:0]       cmd_addr,
  output logic [15:0]      cmd_wdata,
  input  logic             rsp_valid,
  input  logic [15:0]      rsp_data,
  output logic             done,
  output logic             error
);
  localparam int CYC_PER_MS = CLKS_PER_US * US_PER_MS;
  localparam int RST_CYC    = RESET_MS * CYC_PER_MS;
  localparam int PLL_CYC    = PLL_US * CLKS_PER_US;
  localparam int CNT_W      = $clog2(RST_CYC + PLL_CYC + CYC_PER_MS * (2 ** DLY_W)) + 1;
  localparam logic [4:0] LAST_STEP = 5'd16;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_LO, S_RST_HI, S_RD_REQ, S_RD_WAIT,
    S_WR_REQ, S_PAUSE, S_DONE, S_FAIL
  } st_t;

  st_t              st;
  logic [4:0]       step;
  logic             rd_sel;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       fmt_code;
  logic             fmt_ok;
  logic [7:0]       v_sum, h_sum;
  logic [7:0]       wr_addr;
  logic [15:0]      wr_data;

  wire [15:0] cfg_base = (tx_clk_khz == 16'd0) ? 16'h0321 : 16'h0301;
  wire [15:0] cfg_lp   = (cfg_base & ~16'h0001) | 16'h0042;
  wire [15:0] cfg_hs   = cfg_lp | 16'h0009;
  wire        fmt_bad  = (step == 5'd5) && !fmt_ok;
  wire        wr_go    = (st == S_WR_REQ) && !fmt_bad && cmd_ready;
  wire [CNT_W-1:0] d1_cyc = CNT_W'(sleep_exit_ms) * CNT_W'(CYC_PER_MS);
  wire [CNT_W-1:0] d2_cyc = CNT_W'(disp_on_ms) * CNT_W'(CYC_PER_MS);

  assign v_sum = vs_width + v_back;
  assign h_sum = hs_width + h_back;

  always_comb begin
    fmt_ok   = 1'b1;
    fmt_code = 2'd0;
    case (color_bits)
      5'd16:   fmt_code = 2'd0;
      5'd18:   fmt_code = loose18 ? 2'd2 : 2'd1;
      5'd24:   fmt_code = 2'd3;
      default: fmt_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (step)
      5'd0:    begin wr_addr = 8'hB1; wr_data = {vs_width, hs_width}; end
      5'd1:    begin wr_addr = 8'hB2; wr_data = {v_sum, h_sum}; end
      5'd2:    begin wr_addr = 8'hB3; wr_data = {v_front, h_front}; end
      5'd3:    begin wr_addr = 8'hB4; wr_data = h_active; end
      5'd4:    begin wr_addr = 8'hB5; wr_data = v_active; end
      5'd5:    begin wr_addr = 8'hB6; wr_data = {12'h000, 2'b10, fmt_code}; end
      5'd6:    begin wr_addr = 8'hDE; wr_data = {13'h0000, lane_cnt - 3'd1}; end
      5'd7:    begin wr_addr = 8'hB7; wr_data = cfg_lp; end
      5'd8:    begin wr_addr = 8'hBA; wr_data = pll_word; end
      5'd9:    begin wr_addr = 8'hB8; wr_data = 16'h0000; end
      5'd10:   begin wr_addr = 8'hBB; wr_data = lp_div; end
      5'd11:   begin wr_addr = 8'hB9; wr_data = 16'h0001; end
      5'd12,
      5'd14:   begin wr_addr = 8'hBC; wr_data = 16'h0001; end
      5'd13:   begin wr_addr = 8'hBF; wr_data = 16'h0011; end
      5'd15:   begin wr_addr = 8'hBF; wr_data = 16'h0029; end
      default: begin wr_addr = 8'hB7; wr_data = cfg_hs; end
    endcase
  end

  assign bridge_rst_n = (st != S_RST_LO);
  assign cmd_valid    = (st == S_RD_REQ) || ((st == S_WR_REQ) && !fmt_bad);
  assign cmd_write    = (st == S_WR_REQ);
  assign cmd_addr     = (st == S_WR_REQ) ? wr_addr : (rd_sel ? 8'hB7 : 8'hB0);
  assign cmd_wdata    = (st == S_WR_REQ) ? wr_data : 16'h0000;
  assign done         = (st == S_DONE);
  assign error        = (st == S_FAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= '0;
      rd_sel <= 1'b0;
      cnt    <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL:
          if (start) begin
            st     <= S_RST_LO;
            cnt    <= CNT_W'(RST_CYC);
            step   <= '0;
            rd_sel <= 1'b0;
          end
        S_RST_LO:
          if (cnt <= CNT_W'(1)) begin
            st  <= S_RST_HI;
            cnt <= CNT_W'(RST_CYC);
          end else cnt <= cnt - CNT_W'(1);
        S_RST_HI:
          if (cnt <= CNT_W'(1)) st <= readback_en ? S_RD_REQ : S_WR_REQ;
          else cnt <= cnt - CNT_W'(1);
        S_RD_REQ:
          if (cmd_ready) st <= S_RD_WAIT;
        S_RD_WAIT:
          if (rsp_valid) begin
            if (rsp_data != (rd_sel ? 16'h0301 : 16'h2828)) st <= S_FAIL;
            else if (rd_sel) st <= S_WR_REQ;
            else begin
              rd_sel <= 1'b1;
              st     <= S_RD_REQ;
            end
          end
        S_WR_REQ:
          if (fmt_bad) st <= S_FAIL;
          else if (wr_go) begin
            step <= step + 5'd1;
            case (step)
              5'd11:     begin st <= S_PAUSE; cnt <= CNT_W'(PLL_CYC); end
              5'd13:     begin st <= S_PAUSE; cnt <= d1_cyc; end
              5'd15:     begin st <= S_PAUSE; cnt <= d2_cyc; end
              LAST_STEP: st <= S_DONE;
              default:   ;
            endcase
          end
        S_PAUSE:
          if (cnt <= CNT_W'(1)) st <= S_WR_REQ;
          else cnt <= cnt - CNT_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsi_bridge_seq_chk.sv
module dsi_bridge_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        bridge_rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        cmd_write,
  input logic [7:0]  cmd_addr,
  input logic [15:0] cmd_wdata,
  input logic        done,
  input logic        error
);
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_write));

  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_rst_n |-> !cmd_valid);

  a_r1_done_error_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  a_r3_stop_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error && !cmd_valid);

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && !cmd_valid);
endmodule

bind dsi_bridge_seq dsi_bridge_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bridge_rst_n(bridge_rst_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .done(done), .error(error)
);

// File: tb/tb_dsi_bridge_seq.sv
module tb_dsi_bridge_seq;
  localparam int CLK_PERIOD  = 10;
  localparam int CLKS_PER_US = 2;
  localparam int US_PER_MS   = 10;
  localparam int RESET_MS    = 10;
  localparam int PLL_US      = 500;
  localparam int DLY_W       = 8;
  localparam int CYC_MS      = CLKS_PER_US * US_PER_MS;
  localparam int RST_CYC     = RESET_MS * CYC_MS;
  localparam int PLL_CYC     = PLL_US * CLKS_PER_US;

  logic clk = 0, rst_n = 0;
  logic start_main = 0, start_inj = 0;
  wire  start = start_main | start_inj;
  logic readback_en = 0;
  logic [15:0] tx_clk_khz = 0;
  logic [7:0] vs_width = 0, hs_width = 0, v_back = 0, h_back = 0, v_front = 0, h_front = 0;
  logic [15:0] h_active = 0, v_active = 0;
  logic [4:0] color_bits = 0;
  logic loose18 = 0;
  logic [2:0] lane_cnt = 1;
  logic [15:0] pll_word = 0, lp_div = 0;
  logic [DLY_W-1:0] sleep_exit_ms = 0, disp_on_ms = 0;
  logic bridge_rst_n, cmd_valid, cmd_write, done, error;
  logic cmd_ready = 0, rsp_valid = 0;
  logic [7:0] cmd_addr;
  logic [15:0] cmd_wdata, rsp_data = 0;

  dsi_bridge_seq #(.CLKS_PER_US(CLKS_PER_US), .US_PER_MS(US_PER_MS), .RESET_MS(RESET_MS),
                   .PLL_US(PLL_US), .DLY_W(DLY_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .readback_en(readback_en), .tx_clk_khz(tx_clk_khz),
    .vs_width(vs_width), .hs_width(hs_width), .v_back(v_back), .h_back(h_back),
    .v_front(v_front), .h_front(h_front), .h_active(h_active), .v_active(v_active),
    .color_bits(color_bits), .loose18(loose18), .lane_cnt(lane_cnt), .pll_word(pll_word),
    .lp_div(lp_div), .sleep_exit_ms(sleep_exit_ms), .disp_on_ms(disp_on_ms),
    .bridge_rst_n(bridge_rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .error(error));

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed { logic wr; logic [7:0] addr; logic [15:0] data; } item_t;
  item_t exp_q[$];
  int gaps[$];
  int n_checks = 0, n_fail = 0, n_accept = 0, low_total = 0, hi_last = 0;
  logic [15:0] id_val = 16'h2828, cfg_rd_val = 16'h0301, final_cfg = 0;
  bit inject_arm = 0, finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'hB0: return "R3";
      8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5: return "R4";
      8'hB6: return "R5";
      8'hDE: return "R6";
      8'hB7: return "R6/R9";
      8'hBA, 8'hB8, 8'hBB, 8'hB9: return "R7";
      8'hBC, 8'hBF: return "R8";
      default: return "R10";
    endcase
  endfunction

  // monitor and responder: pops the scoreboard on each accepted request
  initial begin
    bit was_low = 0, hi_on = 0, gap_on = 0, rd_pend = 0;
    int hi_cnt = 0, gap_cnt = 0, stall = 0;
    logic [7:0] rd_addr = 0;
    forever begin
      @(negedge clk);
      if (!bridge_rst_n) begin low_total++; was_low = 1; hi_on = 0; end
      else if (was_low) begin was_low = 0; hi_on = 1; hi_cnt = 0; end
      if (hi_on) begin
        if (cmd_valid) begin hi_last = hi_cnt; hi_on = 0; end
        else hi_cnt++;
      end
      if (gap_on) begin
        if (cmd_valid) begin gaps.push_back(gap_cnt); gap_on = 0; end
        else gap_cnt++;
      end
      if (rsp_valid) rsp_valid = 0;
      else if (rd_pend) begin
        rsp_valid = 1;
        rsp_data  = (rd_addr == 8'hB0) ? id_val : cfg_rd_val;
        rd_pend   = 0;
      end
      start_inj = 0;
      if (cmd_valid && stall == 0) begin
        cmd_ready = 1;
        n_accept++;
        if (exp_q.size() == 0)
          check(0, "R10 unexpected request", {7'd0, cmd_write, cmd_addr, cmd_wdata}, 0);
        else begin
          item_t e;
          e = exp_q.pop_front();
          if (e.wr)
            check(cmd_write && cmd_addr == e.addr && cmd_wdata == e.data, req_of(e.addr),
                  {7'd0, cmd_write, cmd_addr, cmd_wdata}, {7'd0, e.wr, e.addr, e.data});
          else
            check(!cmd_write && cmd_addr == e.addr, req_of(e.addr),
                  {7'd0, cmd_write, cmd_addr, 16'h0}, {7'd0, e.wr, e.addr, 16'h0});
        end
        if (!cmd_write) begin rd_pend = 1; rd_addr = cmd_addr; end
        if (cmd_write && (cmd_addr == 8'hB9 || cmd_addr == 8'hBF)) begin gap_on = 1; gap_cnt = 0; end
        if (inject_arm && cmd_write && cmd_addr == 8'hB7 && cmd_wdata == final_cfg) begin
          start_inj  = 1;
          inject_arm = 0;
        end
        stall = n_accept % 3;
      end else begin
        cmd_ready = 0;
        if (cmd_valid && stall > 0) stall--;
      end
    end
  end

  task automatic push(input logic wr, input logic [7:0] a, input logic [15:0] d);
    item_t it;
    it.wr = wr; it.addr = a; it.data = d;
    exp_q.push_back(it);
  endtask

  task automatic push_prefix;
    if (readback_en) begin push(0, 8'hB0, 0); push(0, 8'hB7, 0); end
    push(1, 8'hB1, {vs_width, hs_width});
    push(1, 8'hB2, {8'(vs_width + v_back), 8'(hs_width + h_back)});
    push(1, 8'hB3, {v_front, h_front});
    push(1, 8'hB4, h_active);
    push(1, 8'hB5, v_active);
  endtask

  task automatic push_rest(input logic [1:0] code);
    logic [15:0] lp;
    lp = (tx_clk_khz == 0) ? 16'h0362 : 16'h0342;
    push(1, 8'hB6, 16'h0008 | {14'd0, code});
    push(1, 8'hDE, {13'd0, lane_cnt} - 16'd1);
    push(1, 8'hB7, lp);
    push(1, 8'hBA, pll_word);
    push(1, 8'hB8, 16'h0000);
    push(1, 8'hBB, lp_div);
    push(1, 8'hB9, 16'h0001);
    push(1, 8'hBC, 16'h0001);
    push(1, 8'hBF, 16'h0011);
    push(1, 8'hBC, 16'h0001);
    push(1, 8'hBF, 16'h0029);
    push(1, 8'hB7, lp | 16'h0009);
    final_cfg = lp | 16'h0009;
  endtask

  task automatic pulse_start;
    start_main = 1;
    @(negedge clk);
    start_main = 0;
  endtask

  task automatic wait_end;
    for (int i = 0; i < 20000; i++) begin
      if (done || error) return;
      @(negedge clk);
    end
  endtask

  task automatic full_run(input string tag, input logic [1:0] code, input bit busy_poke);
    int low0, g0;
    low0 = low_total;
    g0   = gaps.size();
    push_prefix();
    push_rest(code);
    pulse_start();
    if (busy_poke) begin
      repeat (300) @(negedge clk);
      pulse_start();
    end
    wait_end();
    check(done && !error, {tag, " R9 done"}, {30'd0, done, error}, 32'h2);
    check(exp_q.size() == 0, {tag, " R4 all writes seen"}, exp_q.size(), 0);
    check(low_total - low0 == RST_CYC, {tag, " R2 reset low width"}, low_total - low0, RST_CYC);
    check(hi_last == RST_CYC, {tag, " R2 reset high width"}, hi_last, RST_CYC);
    check(gaps.size() == g0 + 3, {tag, " R7 gap count"}, gaps.size(), g0 + 3);
    if (gaps.size() == g0 + 3) begin
      check(gaps[g0] == PLL_CYC, {tag, " R7 PLL wait"}, gaps[g0], PLL_CYC);
      check(gaps[g0+1] == sleep_exit_ms * CYC_MS, {tag, " R8 exit-sleep wait"}, gaps[g0+1], sleep_exit_ms * CYC_MS);
      check(gaps[g0+2] == disp_on_ms * CYC_MS, {tag, " R8 display-on wait"}, gaps[g0+2], disp_on_ms * CYC_MS);
    end
    if (busy_poke)
      check(low_total - low0 == RST_CYC, {tag, " R11 busy start ignored"}, low_total - low0, RST_CYC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int acc0, low0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!done && !error, "R1 done/error low", {30'd0, done, error}, 0);
    check(!cmd_valid, "R1 no request", cmd_valid, 0);
    check(bridge_rst_n, "R1 bridge reset released", bridge_rst_n, 1);

    // A: 24 bpp, identity check, transmit clock given, start poked while busy
    readback_en = 1; tx_clk_khz = 16'd24000;
    vs_width = 8'd2; hs_width = 8'd10; v_back = 8'd8; h_back = 8'd40;
    v_front = 8'd4; h_front = 8'd30; h_active = 16'd800; v_active = 16'd480;
    color_bits = 5'd24; loose18 = 0; lane_cnt = 3'd4;
    pll_word = 16'h4214; lp_div = 16'h0005; sleep_exit_ms = 8'd3; disp_on_ms = 8'd5;
    full_run("A", 2'd3, 1);

    // B: loose 18 bpp, pixel clock reference, no read-back, start coincides with last write
    readback_en = 0; tx_clk_khz = 0; color_bits = 5'd18; loose18 = 1; lane_cnt = 3'd2;
    vs_width = 8'd200; v_back = 8'd100; hs_width = 8'd250; h_back = 8'd10;
    sleep_exit_ms = 8'd2; disp_on_ms = 8'd1;
    inject_arm = 1;
    full_run("B", 2'd2, 0);
    low0 = low_total;
    repeat (20) @(negedge clk);
    check(done, "R11 start with final write ignored, done holds", done, 1);
    check(low_total == low0 && bridge_rst_n, "R11 no reset pulse after coincident start", low_total - low0, 0);

    // C: identity mismatch
    readback_en = 1; id_val = 16'h2827;
    push(0, 8'hB0, 0);
    pulse_start();
    wait_end();
    check(error && !done, "R3 bad identity gives error", {30'd0, done, error}, 1);
    acc0 = n_accept;
    repeat (50) @(negedge clk);
    check(n_accept == acc0 && exp_q.size() == 0, "R3 no request after error", n_accept - acc0, 0);
    id_val = 16'h2828;

    // D: restart from error, unsupported depth
    readback_en = 0; tx_clk_khz = 16'd27000; color_bits = 5'd20;
    push_prefix();
    pulse_start();
    wait_end();
    check(error, "R5 bad depth gives error / R11 restart", error, 1);
    acc0 = n_accept;
    repeat (50) @(negedge clk);
    check(n_accept == acc0 && exp_q.size() == 0, "R5 no 0xB6 write", exp_q.size(), 0);

    // E: second identity read mismatch
    readback_en = 1; cfg_rd_val = 16'h0300; color_bits = 5'd16;
    push(0, 8'hB0, 0); push(0, 8'hB7, 0);
    pulse_start();
    wait_end();
    check(error && exp_q.size() == 0, "R3 bad config read-back gives error", {31'd0, error}, 1);
    cfg_rd_val = 16'h0301;

    // F: 16 bpp, one lane
    lane_cnt = 3'd1; sleep_exit_ms = 8'd1; disp_on_ms = 8'd4;
    full_run("F", 2'd0, 0);

    // G: packed 18 bpp, three lanes
    readback_en = 0; color_bits = 5'd18; loose18 = 0; lane_cnt = 3'd3; tx_clk_khz = 0;
    full_run("G", 2'd1, 0);

    finish_run();
  end
endmodule